// File: doc/BRIEF.md
# Four-bit character display initialiser and writer

This block drives a character display controller that is wired over a four-bit data bus with a register-select line, a read/write line and an enable strobe. Out of reset it plays a fixed, timed power-on sequence. It waits for the supply to settle, then sends three wake-up nibbles of value 0x3 and one nibble of 0x2 that selects the narrow bus. It then sends six set-up commands: bus width and line count, display off, clear, entry mode, display on, and a final clear. No busy flag is ever read. Every pause is a fixed number of 20 µs units, and a microsecond tick derived from the system clock counts them.

Once the sequence has finished, the block takes one byte at a time on a valid/ready handshake. A flag with each byte marks it as a character or as a command. Each byte goes out as two enable strobes, high nibble first. The clear and home commands carry a long trailing pause. `in_ready` stays low until the power-on sequence ends. It also stays low while a byte is being strobed and while the pause after that byte runs.

Top module: `lcd4_init_ctrl`

## Requirements
- R1: A prescaler of `CLK_PER_US` clock cycles produces a microsecond tick. A wait of N units lasts exactly N × `UNIT_US` ticks, so every timed interval is a whole number of `CLK_PER_US`-cycle periods.
- R2: During reset and afterwards, `in_ready` and `lcd_en` stay low. The first enable strobe ends no earlier than `PWRUP_U` units after reset is released. `in_ready` cannot rise before all 16 power-on strobes have been sent.
- R3: The first four strobes carry RS=0 with nibbles 0x3, 0x3, 0x3, 0x2. The pauses after them are `LONG1_U`, `LONG2_U`, `NIB_U` and `NIB_U` units, in that order.
- R4: Twelve RS=0 strobes follow, carrying the bytes 0x28, 0x08, 0x01, 0x06, 0x0C, 0x01 in that order. `in_ready` first rises after the sixteenth strobe and the trailing clear pause.
- R5: Every byte goes out on `lcd_db[3:0]`, with bit 0 carrying weight 1. The high nibble is sent first, then the low nibble. Each nibble is followed by `NIB_U` units, and `lcd_rw` is 0 at every strobe.
- R6: RS and data settle at least one tick before `lcd_en` rises and stay unchanged while `lcd_en` is high. `lcd_en` stays high for `EN_US` ticks. Within one sequence, a strobe falls exactly (wait + 2 + `EN_US`) ticks after the previous strobe fell, where wait is the previous strobe's pause in ticks.
- R7: RS equals `in_is_char` for a user byte: 0 for a command, 1 for a character.
- R8: A command byte 0x01 (clear) or 0x02 (home) adds `CLRHOME_U` units after its low nibble. A character with the same code gets only `NIB_U`.
- R9: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then drops, and it rises again exactly when the low nibble's pause ends. `lcd_en` is never high while `in_ready` is high.
- R10: If `in_valid` is already held when `in_ready` rises, the byte is taken on the next edge. Its high-nibble strobe then falls exactly (2 + `EN_US`) ticks after `in_ready` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is offered |
| in_is_char | input | 1 | 1: character write, 0: command write |
| in_byte | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write line, held at write |
| lcd_en | output | 1 | Enable strobe, nibble latched on its fall |
| lcd_db | output | 4 | Four-bit data bus |

## Verification
The end of one byte's trailing pause and the arrival of the next byte can fall in the same cycle. The bench raises `in_valid` while `in_ready` is still low, which is the case for the very first byte, sent during the power-on sequence, and for every back-to-back byte. The bench then measures two things: that `in_ready` rises exactly when the previous pause ends, and that the new high nibble falls a fixed (2 + `EN_US`) ticks later. A byte offered while `in_ready` is already high is also covered, through an idle gap in the sweep, and is judged only against minimum spacing. Every character code and every command code is swept, including clear and home.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;
   localparam int unsigned UNIT_W = 16;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_SETUP,
      ENG_HIGH,
      ENG_WAIT
   } eng_state_t;

   // One unit of work for the strobe engine: an optional nibble strobe
   // followed by a pause counted in delay units.
   typedef struct packed {
      logic              strobe;
      logic              rs;
      logic [3:0]        nib;
      logic [UNIT_W-1:0] wait_u;
   } lcd_step_t;
endpackage

// File: rtl/lcd4_us_tick.sv
module lcd4_us_tick #(
   parameter int unsigned CLK_PER_US = 50
)(
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   logic [PW-1:0] cnt_q;

   generate
      if ((CLK_PER_US & (CLK_PER_US - 1)) == 0) begin : g_pow2
         // Power-of-two period: let the counter wrap on its own.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign tick = &cnt_q;
      end else begin : g_cmp
         localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/lcd4_strobe_eng.sv
module lcd4_strobe_eng
   import lcd4_pkg::*;
#(
   parameter int unsigned UNIT_US = 20,
   parameter int unsigned EN_US   = 1,
   parameter int unsigned CW      = 20
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      step_valid,
   input  lcd_step_t step,
   output logic      step_take,
   output logic      idle,
   output logic      en,
   output logic      rs,
   output logic [3:0] db
);
   eng_state_t    st_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] wait_q;
   logic          rs_q;
   logic [3:0]    db_q;
   logic          cnt_last;

   assign idle      = (st_q == ENG_IDLE);
   assign step_take = idle && step_valid;
   assign cnt_last  = tick && (cnt_q == CW'(1));
   assign en        = (st_q == ENG_HIGH);
   assign rs        = rs_q;
   assign db        = db_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         cnt_q  <= '0;
         wait_q <= '0;
         rs_q   <= 1'b0;
         db_q   <= '0;
      end else begin
         case (st_q)
            ENG_IDLE: begin
               if (step_valid) begin
                  wait_q <= CW'(step.wait_u) * CW'(UNIT_US);
                  if (step.strobe) begin
                     rs_q  <= step.rs;
                     db_q  <= step.nib;
                     cnt_q <= CW'(2);
                     st_q  <= ENG_SETUP;
                  end else begin
                     cnt_q <= CW'(step.wait_u) * CW'(UNIT_US);
                     st_q  <= ENG_WAIT;
                  end
               end
            end
            ENG_SETUP: begin
               if (cnt_last) begin
                  cnt_q <= CW'(EN_US);
                  st_q  <= ENG_HIGH;
               end else if (tick) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ENG_HIGH: begin
               if (cnt_last) begin
                  cnt_q <= wait_q;
                  st_q  <= ENG_WAIT;
               end else if (tick) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ENG_WAIT: begin
               if (cnt_last)  st_q  <= ENG_IDLE;
               else if (tick) cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lcd4_seq.sv
module lcd4_seq
   import lcd4_pkg::*;
#(
   parameter int unsigned PWRUP_U   = 1000,
   parameter int unsigned LONG1_U   = 205,
   parameter int unsigned LONG2_U   = 5,
   parameter int unsigned NIB_U     = 2,
   parameter int unsigned CLRHOME_U = 100
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_is_char,
   input  logic [7:0] in_byte,
   output logic       in_ready,
   input  logic       eng_idle,
   input  logic       step_take,
   output logic       step_valid,
   output lcd_step_t  step
);
   localparam int unsigned N_INIT = 17;   // one settle pause, 4 wake nibbles, 6 bytes
   localparam int unsigned IW     = $clog2(N_INIT);

   logic          run_q;
   logic [IW-1:0] idx_q;
   logic [1:0]    sub_q;   // 0 none, 1 high nibble pending, 2 low nibble pending
   logic [7:0]    byte_q;
   logic          char_q;

   function automatic lcd_step_t mk_step(input logic strobe, input logic rsv,
                                         input logic [3:0] nib, input int unsigned wu);
      lcd_step_t s;
      s.strobe = strobe;
      s.rs     = rsv;
      s.nib    = nib;
      s.wait_u = UNIT_W'(wu);
      return s;
   endfunction

   function automatic lcd_step_t byte_step(input logic [7:0] b, input logic rsv, input logic lo);
      int unsigned wu;
      wu = NIB_U;
      if (lo && !rsv && (b == 8'h01 || b == 8'h02)) wu = NIB_U + CLRHOME_U;
      return mk_step(1'b1, rsv, lo ? b[3:0] : b[7:4], wu);
   endfunction

   function automatic logic [7:0] init_cmd(input int unsigned k);
      case (k)
         0:       return 8'h28;
         1:       return 8'h08;
         2:       return 8'h01;
         3:       return 8'h06;
         4:       return 8'h0C;
         default: return 8'h01;
      endcase
   endfunction

   function automatic lcd_step_t init_step(input logic [IW-1:0] idx);
      int unsigned i;
      int unsigned k;
      i = 32'(idx);
      k = (i >= 5) ? i - 5 : 0;
      case (i)
         0:       return mk_step(1'b0, 1'b0, 4'h0, PWRUP_U);
         1:       return mk_step(1'b1, 1'b0, 4'h3, LONG1_U);
         2:       return mk_step(1'b1, 1'b0, 4'h3, LONG2_U);
         3:       return mk_step(1'b1, 1'b0, 4'h3, NIB_U);
         4:       return mk_step(1'b1, 1'b0, 4'h2, NIB_U);
         default: return byte_step(init_cmd(k / 2), 1'b0, k[0]);
      endcase
   endfunction

   always_comb begin
      if (!run_q) begin
         step_valid = 1'b1;
         step       = init_step(idx_q);
      end else begin
         step_valid = (sub_q != 2'd0);
         step       = byte_step(byte_q, char_q, sub_q == 2'd2);
      end
   end

   assign in_ready = run_q && eng_idle && (sub_q == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         idx_q  <= '0;
         sub_q  <= 2'd0;
         byte_q <= '0;
         char_q <= 1'b0;
      end else if (!run_q) begin
         if (step_take) begin
            if (idx_q == IW'(N_INIT - 1)) run_q <= 1'b1;
            else                          idx_q <= idx_q + 1'b1;
         end
      end else if (in_valid && in_ready) begin
         byte_q <= in_byte;
         char_q <= in_is_char;
         sub_q  <= 2'd1;
      end else if (step_take) begin
         sub_q <= (sub_q == 2'd1) ? 2'd2 : 2'd0;
      end
   end
endmodule

// File: rtl/lcd4_init_ctrl.sv
module lcd4_init_ctrl
   import lcd4_pkg::*;
#(
   parameter int unsigned CLK_PER_US = 50,
   parameter int unsigned UNIT_US    = 20,
   parameter int unsigned EN_US      = 1,
   parameter int unsigned PWRUP_U    = 1000,
   parameter int unsigned LONG1_U    = 205,
   parameter int unsigned LONG2_U    = 5,
   parameter int unsigned NIB_U      = 2,
   parameter int unsigned CLRHOME_U  = 100
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_is_char,
   input  logic [7:0] in_byte,
   output logic       in_ready,
   output logic       lcd_rs,
   output logic       lcd_rw,
   output logic       lcd_en,
   output logic [3:0] lcd_db
);
   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   localparam int unsigned MAX_WAIT_U =
      umax(umax(PWRUP_U, LONG1_U), umax(LONG2_U, NIB_U + CLRHOME_U));
   localparam int unsigned CW = $clog2(MAX_WAIT_U * UNIT_US + EN_US + 3) + 1;

   generate
      if (CLK_PER_US < 2) begin : g_bad_clk
         $error("lcd4_init_ctrl: CLK_PER_US must be 2 or more");
      end
      if (UNIT_US < 1 || EN_US < 1) begin : g_bad_tick
         $error("lcd4_init_ctrl: UNIT_US and EN_US must be 1 or more");
      end
      if (PWRUP_U < 1 || LONG1_U < 1 || LONG2_U < 1 || NIB_U < 1) begin : g_bad_wait
         $error("lcd4_init_ctrl: every pause must be at least one unit");
      end
      if (MAX_WAIT_U >= (1 << UNIT_W)) begin : g_bad_range
         $error("lcd4_init_ctrl: a pause exceeds the unit field width");
      end
   endgenerate

   logic      us_tick;
   logic      eng_idle;
   logic      step_take;
   logic      step_valid;
   lcd_step_t cur_step;

   lcd4_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (us_tick)
   );

   lcd4_seq #(
      .PWRUP_U  (PWRUP_U),
      .LONG1_U  (LONG1_U),
      .LONG2_U  (LONG2_U),
      .NIB_U    (NIB_U),
      .CLRHOME_U(CLRHOME_U)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_is_char(in_is_char),
      .in_byte   (in_byte),
      .in_ready  (in_ready),
      .eng_idle  (eng_idle),
      .step_take (step_take),
      .step_valid(step_valid),
      .step      (cur_step)
   );

   lcd4_strobe_eng #(
      .UNIT_US(UNIT_US),
      .EN_US  (EN_US),
      .CW     (CW)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (us_tick),
      .step_valid(step_valid),
      .step      (cur_step),
      .step_take (step_take),
      .idle      (eng_idle),
      .en        (lcd_en),
      .rs        (lcd_rs),
      .db        (lcd_db)
   );

   assign lcd_rw = 1'b0;
endmodule

// File: rtl/lcd4_init_ctrl_chk.sv
module lcd4_init_ctrl_chk #(
   parameter int unsigned CLK_PER_US = 50,
   parameter int unsigned UNIT_US    = 20,
   parameter int unsigned EN_US      = 1,
   parameter int unsigned PWRUP_U    = 1000
)(
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       lcd_en,
   input logic       lcd_rs,
   input logic [3:0] lcd_db
);
   localparam longint unsigned QUIET_CYC = longint'(PWRUP_U) * UNIT_US * CLK_PER_US;
   localparam longint unsigned EN_CYC    = longint'(EN_US) * CLK_PER_US;

   logic [39:0] since_rst_q;
   logic [39:0] hi_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst_q <= '0;
         hi_cnt_q    <= '0;
      end else begin
         if (since_rst_q < 40'(QUIET_CYC)) since_rst_q <= since_rst_q + 1'b1;
         hi_cnt_q <= lcd_en ? hi_cnt_q + 1'b1 : '0;
      end
   end

   a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q < 40'(QUIET_CYC)) |-> (!in_ready && !lcd_en));

   a_r6_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && $past(lcd_en)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

   a_r6_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

   a_r6_enable_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> (hi_cnt_q >= 40'(EN_CYC)));

   a_r9_ready_excludes_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !lcd_en);

   a_r9_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
endmodule

bind lcd4_init_ctrl lcd4_init_ctrl_chk #(
   .CLK_PER_US(CLK_PER_US),
   .UNIT_US   (UNIT_US),
   .EN_US     (EN_US),
   .PWRUP_U   (PWRUP_U)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_valid(in_valid),
   .in_ready(in_ready),
   .lcd_en  (lcd_en),
   .lcd_rs  (lcd_rs),
   .lcd_db  (lcd_db)
);

// File: tb/lcd4_init_ctrl_tb.sv
module lcd4_init_ctrl_tb_top;
   localparam int CLK   = 4;
   localparam int UNIT  = 2;
   localparam int ENUS  = 1;
   localparam int PWRU  = 1000;
   localparam int L1U   = 205;
   localparam int L2U   = 5;
   localparam int NIBU  = 2;
   localparam int CLRU  = 100;
   localparam int MAXE  = 1100;
   localparam int WDOG  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_is_char = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_ready;
   logic       lcd_rs;
   logic       lcd_rw;
   logic       lcd_en;
   logic [3:0] lcd_db;

   always #10 clk = ~clk;   // 50 MHz

   lcd4_init_ctrl #(
      .CLK_PER_US(CLK), .UNIT_US(UNIT), .EN_US(ENUS), .PWRUP_U(PWRU),
      .LONG1_U(L1U), .LONG2_U(L2U), .NIB_U(NIBU), .CLRHOME_U(CLRU)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_char(in_is_char),
      .in_byte(in_byte), .in_ready(in_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
      .lcd_en(lcd_en), .lcd_db(lcd_db)
   );

   // expected strobe list; mode 1 exact from previous fall, 2 exact from
   // ready rise, 3 minimum from previous fall
   logic       e_rs   [MAXE];
   logic [3:0] e_nib  [MAXE];
   int         e_wait [MAXE];
   int         e_mode [MAXE];
   int         n_exp = 0;
   int         n_seen = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   longint     cyc = 0;
   longint     rel_cyc = 0;
   longint     chg_cyc = 0;
   longint     last_fall = 0;
   longint     last_rdy = 0;
   logic       en_prev = 1'b0;
   logic       rdy_prev = 1'b0;
   logic       rs_prev = 1'b0;
   logic [3:0] db_prev = 4'h0;
   logic       rise_rs = 1'b0;
   logic [3:0] rise_db = 4'h0;
   bit         done = 1'b0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint got, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic push(input logic rs, input logic [3:0] nib, input int wu, input int mode);
      e_rs[n_exp]   = rs;
      e_nib[n_exp]  = nib;
      e_wait[n_exp] = wu;
      e_mode[n_exp] = mode;
      n_exp++;
   endtask

   task automatic push_byte(input logic rs, input logic [7:0] b, input int hi_mode);
      int lw;
      lw = NIBU;
      if (!rs && (b == 8'h01 || b == 8'h02)) lw = NIBU + CLRU;
      push(rs, b[7:4], NIBU, hi_mode);
      push(rs, b[3:0], lw, 1);
   endtask

   function automatic longint gap_after(input int wu);
      return longint'(CLK) * (longint'(UNIT) * wu + 2 + ENUS);
   endfunction

   task automatic send(input logic is_char, input logic [7:0] b);
      @(negedge clk);
      push_byte(is_char, b, in_ready ? 3 : 2);
      in_valid   = 1'b1;
      in_is_char = is_char;
      in_byte    = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(lcd_en == 1'b0, "R2", "enable during reset", longint'(lcd_en), 0);
         chk(in_ready == 1'b0, "R2", "ready during reset", longint'(in_ready), 0);
         rel_cyc = cyc;
         chg_cyc = cyc;
      end else if (!done) begin
         if (lcd_db !== db_prev || lcd_rs !== rs_prev) chg_cyc = cyc;
         if (lcd_en && !en_prev) begin
            chk(cyc - chg_cyc >= CLK, "R6", "setup cycles before enable", cyc - chg_cyc, CLK);
            rise_db = lcd_db;
            rise_rs = lcd_rs;
         end
         if (!lcd_en && en_prev) begin
            if (n_seen >= n_exp) begin
               chk(1'b0, "R9", "strobe without a byte", n_seen, n_exp);
            end else begin
               chk(lcd_rs == e_rs[n_seen], (n_seen < 4) ? "R3" : (n_seen < 16) ? "R4" : "R7",
                   "register select", longint'(lcd_rs), longint'(e_rs[n_seen]));
               chk(lcd_db == e_nib[n_seen], (n_seen < 4) ? "R3" : (n_seen < 16) ? "R4" : "R5",
                   "nibble", longint'(lcd_db), longint'(e_nib[n_seen]));
               chk(lcd_db == rise_db && lcd_rs == rise_rs, "R6", "data moved while enable high",
                   longint'(lcd_db), longint'(rise_db));
               chk(lcd_rw == 1'b0, "R5", "read/write line", longint'(lcd_rw), 0);
               chk(in_ready == 1'b0, "R9", "ready during transfer", longint'(in_ready), 0);
               if (n_seen == 0) begin
                  chk(cyc - rel_cyc >= longint'(PWRU) * UNIT * CLK, "R2", "power-up pause",
                      cyc - rel_cyc, longint'(PWRU) * UNIT * CLK);
               end else if (e_mode[n_seen] == 1) begin
                  chk(cyc - last_fall == gap_after(e_wait[n_seen-1]),
                      (n_seen < 16) ? "R3" : "R6", "strobe spacing",
                      cyc - last_fall, gap_after(e_wait[n_seen-1]));
               end else if (e_mode[n_seen] == 2) begin
                  chk(cyc - last_rdy == longint'(CLK) * (2 + ENUS), "R10", "ready rise to first strobe",
                      cyc - last_rdy, longint'(CLK) * (2 + ENUS));
               end else begin
                  chk(cyc - last_fall >= gap_after(e_wait[n_seen-1]), "R9", "minimum spacing",
                      cyc - last_fall, gap_after(e_wait[n_seen-1]));
               end
               last_fall = cyc;
               n_seen++;
            end
         end
         if (in_ready && !rdy_prev) begin
            if (!(n_seen > 16)) chk(n_seen == 16, "R4", "strobes before first ready", n_seen, 16);
            if (n_seen > 0) begin
               chk(cyc - last_fall == longint'(CLK) * UNIT * e_wait[n_seen-1],
                   (e_wait[n_seen-1] != NIBU) ? "R8" : "R1", "pause before ready",
                   cyc - last_fall, longint'(CLK) * UNIT * e_wait[n_seen-1]);
            end
            last_rdy = cyc;
         end
         if (in_ready && n_seen < 16) chk(1'b0, "R2", "ready before init end", n_seen, 16);
         en_prev  = lcd_en;
         rdy_prev = in_ready;
         db_prev  = lcd_db;
         rs_prev  = lcd_rs;
      end
   end

   initial begin
      push(1'b0, 4'h3, L1U, 1);
      push(1'b0, 4'h3, L2U, 1);
      push(1'b0, 4'h3, NIBU, 1);
      push(1'b0, 4'h2, NIBU, 1);
      push_byte(1'b0, 8'h28, 1);
      push_byte(1'b0, 8'h08, 1);
      push_byte(1'b0, 8'h01, 1);
      push_byte(1'b0, 8'h06, 1);
      push_byte(1'b0, 8'h0C, 1);
      push_byte(1'b0, 8'h01, 1);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // offered during init: taken the edge after ready first rises
      send(1'b1, 8'h41);
      for (int b = 0; b < 256; b++) send(1'b1, 8'(b));
      // idle gap so the next byte meets ready already high
      while (!in_ready) @(negedge clk);
      repeat (37) @(negedge clk);
      for (int b = 0; b < 256; b++) send(1'b0, 8'(b));
      while (!(n_seen == n_exp && in_ready)) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(n_seen == n_exp, "R5", "total strobes", n_seen, n_exp);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual %0d strobes expected %0d", n_seen, n_exp);
         done = 1'b1;
         summary();
         $finish;
      end
   end
endmodule